// File: doc/BRIEF.md
# PHY Configuration Write Sequencer

This block performs one write into a PHY's internal configuration space. The PHY exposes that space through a single masked control register. Each write to that register carries a value half and a mask half, and only the bits whose mask bit is set are updated. A requester hands the sequencer a configuration address and a data nibble with a valid/ready handshake. The sequencer then issues three masked register writes in a fixed order, with a settle gap between them, and pulses `done` when the write has landed.

The three writes are:
- a field write that places the nibble and the address in their register fields;
- a write that raises the strobe bit;
- a write that clears the strobe bit again.

The settle gap is `CYC_PER_US * SETTLE_US` clock cycles. Both are parameters, so the same block serves any clock rate. While a write is in flight the sequencer holds `req_ready` low, and it only takes the next request once `done` has pulsed.

Top module: `phycfg_wr_seq`

## Requirements
- R1: After reset, `req_ready` is 1, while `done` and `cfg_we` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle after the `done` pulse.
- R3: In the cycle after acceptance, `cfg_we` is 1 for the field write, with the following contents:
  - `cfg_msk` = 16'h07FE;
  - `cfg_val[10:7]` holds the data nibble;
  - `cfg_val[6:1]` holds the address;
  - all other value bits are 0.
- R4: The strobe write comes exactly GAP = `CYC_PER_US*SETTLE_US` cycles after the field write, with `cfg_val` = 16'h0001 and `cfg_msk` = 16'h0001.
- R5: The strobe-clear write comes exactly GAP cycles after the strobe write, with `cfg_val` = 16'h0000 and `cfg_msk` = 16'h0001.
- R6: `done` is a single-cycle pulse in the cycle right after the strobe-clear write.
- R7: `cfg_we` is 1 in exactly the three write cycles of each request and 0 in every other cycle.
- R8: When the address or data inputs are wider than their fields (6 and 4 bits), only their low bits are used and the rest are discarded.
- R9: While a request is in flight, changes on `req_valid`, `req_addr` and `req_data` have no effect on the current write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | IN_ADDR_W | Configuration address |
| req_data | input | IN_DATA_W | Configuration data |
| done | output | 1 | One-cycle completion pulse |
| cfg_we | output | 1 | Masked register write strobe |
| cfg_val | output | 16 | Value half of the masked write |
| cfg_msk | output | 16 | Mask half of the masked write: set bits are written |

## Verification
The bench drives the sequencer with four kinds of stimulus:
- **Mid-range address/data pairs.** These show whether each field lands in its own bit range.
- **All-zero and all-one inputs wider than the fields.** These expose both a shifted field and a truncation that keeps the wrong bits.
- **Back-to-back requests.** These separate correct turnaround after `done` from a sequencer that accepts early or stalls a cycle.
- **Inputs changing while a write is in flight.** These show whether the latched request is insulated from later bus activity.

A reference model predicts every output in every cycle. An off-by-one settle gap or a misplaced `done` is therefore caught in the very cycle it occurs.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

    localparam int REG_W        = 16;
    localparam int FLD_ADDR_LSB = 1;
    localparam int FLD_ADDR_W   = 6;
    localparam int FLD_DATA_LSB = 7;
    localparam int FLD_DATA_W   = 4;
    localparam int STB_BIT      = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_GAP1,
        S_STB,
        S_GAP2,
        S_CLR,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_FIELDS,
        STEP_STB_SET,
        STEP_STB_CLR
    } step_e;

    typedef struct packed {
        logic [FLD_ADDR_W-1:0] addr;
        logic [FLD_DATA_W-1:0] data;
    } cfg_req_t;

    typedef struct packed {
        logic             we;
        logic [REG_W-1:0] val;
        logic [REG_W-1:0] msk;
    } mwr_t;

    function automatic logic [REG_W-1:0] fld_mask(int lsb, int width);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] place_fields(cfg_req_t r);
        logic [REG_W-1:0] v;
        v = '0;
        v[FLD_DATA_LSB +: FLD_DATA_W] = r.data;
        v[FLD_ADDR_LSB +: FLD_ADDR_W] = r.addr;
        return v;
    endfunction

    localparam logic [REG_W-1:0] FIELDS_MSK =
        fld_mask(FLD_DATA_LSB, FLD_DATA_W) | fld_mask(FLD_ADDR_LSB, FLD_ADDR_W);
    localparam logic [REG_W-1:0] STB_MSK = fld_mask(STB_BIT, 1);

endpackage

// File: rtl/phycfg_req_latch.sv
module phycfg_req_latch
    import phycfg_pkg::*;
#(
    parameter int IN_ADDR_W = 6,
    parameter int IN_DATA_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [IN_ADDR_W-1:0] in_addr,
    input  logic [IN_DATA_W-1:0] in_data,
    output cfg_req_t             held
);

    logic [FLD_ADDR_W-1:0] addr_fit;
    logic [FLD_DATA_W-1:0] data_fit;

    generate
        if (IN_ADDR_W >= FLD_ADDR_W) begin : g_addr_cut
            assign addr_fit = in_addr[FLD_ADDR_W-1:0];
        end else begin : g_addr_ext
            assign addr_fit = {{(FLD_ADDR_W-IN_ADDR_W){1'b0}}, in_addr};
        end

        if (IN_DATA_W >= FLD_DATA_W) begin : g_data_cut
            assign data_fit = in_data[FLD_DATA_W-1:0];
        end else begin : g_data_ext
            assign data_fit = {{(FLD_DATA_W-IN_DATA_W){1'b0}}, in_data};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held.addr <= addr_fit;
            held.data <= data_fit;
        end
    end

endmodule

// File: rtl/phycfg_gap_timer.sv
module phycfg_gap_timer #(
    parameter int GAP = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);

    localparam int CNT_W = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(GAP - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == CNT_W'(1));

endmodule

// File: rtl/phycfg_word_fmt.sv
module phycfg_word_fmt
    import phycfg_pkg::*;
(
    input  step_e    step,
    input  cfg_req_t req,
    output mwr_t     wr
);

    always_comb begin
        wr = '0;
        unique case (step)
            STEP_FIELDS: begin
                wr.we  = 1'b1;
                wr.val = place_fields(req);
                wr.msk = FIELDS_MSK;
            end
            STEP_STB_SET: begin
                wr.we  = 1'b1;
                wr.val = STB_MSK;
                wr.msk = STB_MSK;
            end
            STEP_STB_CLR: begin
                wr.we  = 1'b1;
                wr.val = '0;
                wr.msk = STB_MSK;
            end
            default: wr = '0;
        endcase
    end

endmodule

// File: rtl/phycfg_wr_seq.sv
module phycfg_wr_seq
    import phycfg_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int SETTLE_US  = 1,
    parameter int IN_ADDR_W  = 6,
    parameter int IN_DATA_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [IN_ADDR_W-1:0] req_addr,
    input  logic [IN_DATA_W-1:0] req_data,
    output logic                 done,
    output logic                 cfg_we,
    output logic [REG_W-1:0]     cfg_val,
    output logic [REG_W-1:0]     cfg_msk
);

    localparam int GAP = (CYC_PER_US * SETTLE_US < 1) ? 1 : CYC_PER_US * SETTLE_US;

    seq_state_e state, state_nx;
    step_e      step;
    cfg_req_t   held;
    mwr_t       wr;
    logic       accept;
    logic       gap_start;
    logic       gap_over;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign done      = (state == S_DONE);
    assign gap_start = (state == S_LOAD) || (state == S_STB);

    phycfg_req_latch #(
        .IN_ADDR_W (IN_ADDR_W),
        .IN_DATA_W (IN_DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .in_addr (req_addr),
        .in_data (req_data),
        .held    (held)
    );

    phycfg_gap_timer #(
        .GAP (GAP)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (gap_start),
        .expired (gap_over)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_LOAD;
            S_LOAD:  state_nx = (GAP == 1) ? S_STB : S_GAP1;
            S_GAP1:  if (gap_over) state_nx = S_STB;
            S_STB:   state_nx = (GAP == 1) ? S_CLR : S_GAP2;
            S_GAP2:  if (gap_over) state_nx = S_CLR;
            S_CLR:   state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_LOAD:  step = STEP_FIELDS;
            S_STB:   step = STEP_STB_SET;
            S_CLR:   step = STEP_STB_CLR;
            default: step = STEP_NONE;
        endcase
    end

    phycfg_word_fmt u_fmt (
        .step (step),
        .req  (held),
        .wr   (wr)
    );

    assign cfg_we  = wr.we;
    assign cfg_val = wr.val;
    assign cfg_msk = wr.msk;

endmodule

// File: rtl/phycfg_wr_seq_chk.sv
module phycfg_wr_seq_chk
    import phycfg_pkg::*;
#(
    parameter int GAP = 100
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_val,
    input logic [REG_W-1:0] cfg_msk
);

    localparam int GW = $clog2(GAP + 1) + 1;

    logic [GW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)                 since <= '1;
        else if (cfg_we)         since <= '0;
        else if (since != '1)    since <= since + GW'(1);
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_fields_follow_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cfg_we && cfg_msk == FIELDS_MSK));

    a_r3_value_inside_mask: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> ((cfg_val & ~cfg_msk) == '0));

    a_r4_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_msk == STB_MSK && cfg_val[STB_BIT]) |-> (since == GW'(GAP - 1)));

    a_r5_clear_spacing: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_msk == STB_MSK && !cfg_val[STB_BIT]) |-> (since == GW'(GAP - 1)));

    a_r6_done_after_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(cfg_we) && $past(cfg_msk) == STB_MSK && !$past(cfg_val[STB_BIT])));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_no_write_when_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cfg_we);

endmodule

bind phycfg_wr_seq phycfg_wr_seq_chk #(.GAP(GAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .cfg_we    (cfg_we),
    .cfg_val   (cfg_val),
    .cfg_msk   (cfg_msk)
);

// File: tb/tb_phycfg_wr_seq.sv
module tb_phycfg_wr_seq;

    localparam int CPU = 3;
    localparam int SUS = 1;
    localparam int G   = CPU * SUS;
    localparam int AW  = 8;
    localparam int DW  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          done;
    logic          cfg_we;
    logic [15:0]   cfg_val;
    logic [15:0]   cfg_msk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    phycfg_wr_seq #(
        .CYC_PER_US (CPU),
        .SETTLE_US  (SUS),
        .IN_ADDR_W  (AW),
        .IN_DATA_W  (DW)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .done      (done),
        .cfg_we    (cfg_we),
        .cfg_val   (cfg_val),
        .cfg_msk   (cfg_msk)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] fields(logic [AW-1:0] a, logic [DW-1:0] d);
        int v;
        v = ((int'(d) & 15) << 7) | ((int'(a) & 63) << 1);
        return v[15:0];
    endfunction

    // Behavioural reference: busy flag plus cycles since acceptance.
    bit            m_busy = 1'b0;
    int            m_t = 0;
    logic [AW-1:0] m_a;
    logic [DW-1:0] m_d;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0;
            m_t    = 0;
        end else if (m_busy) begin
            if (m_t == 2 * G + 2) m_busy = 1'b0;
            else                  m_t++;
        end else if (req_valid) begin
            m_busy = 1'b1;
            m_t    = 1;
            m_a    = req_addr;
            m_d    = req_data;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit exp_ready, exp_done, exp_we;
            exp_ready = !m_busy;
            exp_done  = m_busy && (m_t == 2 * G + 2);
            exp_we    = m_busy && (m_t == 1 || m_t == 1 + G || m_t == 1 + 2 * G);
            chk(req_ready == exp_ready, "R2 ready", 32'(req_ready), 32'(exp_ready));
            chk(done == exp_done, "R6 done", 32'(done), 32'(exp_done));
            chk(cfg_we == exp_we, "R7 write enable", 32'(cfg_we), 32'(exp_we));
            if (exp_we && m_t == 1) begin
                chk(cfg_val == fields(m_a, m_d), "R3 field value", 32'(cfg_val), 32'(fields(m_a, m_d)));
                chk(cfg_msk == 16'h07FE, "R3 field mask", 32'(cfg_msk), 32'h07FE);
            end else if (exp_we && m_t == 1 + G) begin
                chk(cfg_val == 16'h0001 && cfg_msk == 16'h0001, "R4 strobe set",
                    {cfg_val, cfg_msk}, 32'h0001_0001);
            end else if (exp_we) begin
                chk(cfg_val == 16'h0000 && cfg_msk == 16'h0001, "R5 strobe clear",
                    {cfg_val, cfg_msk}, 32'h0000_0001);
            end
        end
    end

    task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, bit noise, string tag);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
        if (noise) begin
            req_addr = ~a;
            req_data = ~d;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        chk(cfg_we && cfg_val == fields(a, d), tag, 32'(cfg_val), 32'(fields(a, d)));
        if (noise) begin
            for (int i = 0; i < G; i++) begin
                @(posedge clk);
                #1;
                req_addr = req_addr + 8'd37;
                req_data = req_data ^ 6'h15;
            end
            @(posedge clk);
            #1;
            req_valid = 1'b0;
        end
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && cfg_we == 1'b0, "R1 reset state",
            {29'd0, req_ready, done, cfg_we}, 32'h4);

        send(8'h15, 6'h0A, 1'b0, "R3 basic fields");
        send(8'h2A, 6'h05, 1'b1, "R9 busy inputs ignored");
        send(8'hFF, 6'h3F, 1'b0, "R8 truncation all ones");
        send(8'h00, 6'h00, 1'b0, "R3 zero fields");
        send(8'hC1, 6'h21, 1'b0, "R8 truncation high bits");
        send(8'h3F, 6'h0F, 1'b0, "R2 back to back");
        repeat (6) @(posedge clk);
        #1;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule